// File: doc/BRIEF.md
# Schedule Run/Stop and Single-Step Sequencer

This block decides when a frame-based host controller walks its transfer schedule. Software drives two control bits, a run bit and a debug bit, through a write port. The block keeps a frame timer and a frame-number register. At each frame boundary it emits a one-cycle start-of-frame pulse. It also reports whether the schedule walker is halted. A descriptor engine sits beside it and is modelled as a plain request/response port. The sequencer raises `fetch_en` when a descriptor may be fetched. The engine answers with `desc_valid`, `desc_active` and `desc_last`, and later reports `exec_done`.

The debug bit changes what a stop means. With debug clear, a stop rewinds the frame timer to zero. The next run then starts a fresh frame at whatever frame number software has loaded. With debug set, a stop freezes the timer where it is, and the next run continues from that point. In debug mode, fetching an active descriptor also clears the run bit. The controller therefore executes exactly one descriptor and then halts (single step). Inactive descriptors are passed over. If the stepped descriptor was the last one of its frame, the controller first waits for the next frame to start. It then fetches that frame's first descriptor and halts.

Top module: `sched_runctl`

## Requirements
- R1: After synchronous reset: `halted`=1, `run_bit`=0, `dbg_bit`=0, `fetch_en`=0, `sof`=0, `frame_timer`=0, `frame_num`=0.
- R2: While not halted, `frame_timer` steps 0,1,…,TICKS_PER_FRAME-1 and wraps to 0. `sof` is high for the one cycle in which the timer holds TICKS_PER_FRAME-1. At the edge that ends that cycle, `frame_num` increments modulo 2^FRAME_BITS (1024 by default).
- R3: A write with `cmd_run`=1 while halted clears `halted` and sets `run_bit` at that same clock edge. In the following cycle `fetch_en` is 1 and the timer starts from its held value.
- R4: With debug clear and no descriptor in progress, a write with `cmd_run`=0 sets `halted` at that edge and forces `frame_timer` to 0. `frame_num` is kept. The next run counts from 0 at the kept frame number.
- R5: A descriptor accepted (`fetch_en`&`desc_valid`&`desc_active`) is never abandoned. If the run bit is cleared while it executes, `fetch_en` stays 0 and `halted` stays 0 until `exec_done`. `halted` rises at the edge where `exec_done` is sampled.
- R6: A `fnum_wr` write loads `frame_num` only while `halted`=1. A write while running leaves `frame_num` unchanged.
- R7: With debug set, a stop freezes `frame_timer` and `frame_num`. A later run continues counting from the frozen timer value.
- R8: With debug set and running, accepting an active descriptor clears `run_bit` at that edge and drops `fetch_en`. The controller then halts at the edge where `exec_done` is sampled.
- R9: A descriptor delivered with `desc_active`=0 is skipped. `run_bit` and `fetch_en` stay 1, and the controller does not halt.
- R10: After an executed descriptor flagged `desc_last`, `fetch_en` stays 0 until the next `sof`. In a single step, the controller then raises `fetch_en` and halts at the edge where the next descriptor is delivered.
- R11: If a software write with `cmd_run`=1 lands in the same cycle as the hardware clear of R8, the hardware clear wins and `run_bit` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Software write strobe for the run and debug bits |
| cmd_run | input | 1 | Run value written |
| cmd_dbg | input | 1 | Debug value written |
| fnum_wr | input | 1 | Frame-number write strobe |
| fnum_wdata | input | FRAME_BITS | Frame-number write value |
| desc_valid | input | 1 | Engine delivers a descriptor this cycle |
| desc_active | input | 1 | Delivered descriptor is active |
| desc_last | input | 1 | Executed descriptor is last in its frame (sampled with exec_done) |
| exec_done | input | 1 | Engine finished the accepted descriptor |
| fetch_en | output | 1 | Engine may fetch a descriptor |
| run_bit | output | 1 | Current run bit |
| dbg_bit | output | 1 | Current debug bit |
| halted | output | 1 | Schedule walk halted |
| sof | output | 1 | Start-of-frame pulse |
| frame_timer | output | TW | Ticks into the current frame |
| frame_num | output | FRAME_BITS | Frame-number register |

## Verification
Two events can land in the same cycle. The first pair is the hardware run-bit clear at an active fetch and a software write that sets the run bit. The bench presents an active descriptor and a run write together and expects `run_bit` low afterwards. The second pair is `exec_done` on a last-in-frame step and the start-of-frame edge. The bench lines up `exec_done` with the `sof` cycle. It then checks that the controller ignores that boundary and waits a whole further frame, with `fetch_en` low, before the final fetch and halt.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [2:0] {
    ST_HALT   = 3'd0,
    ST_RUN    = 3'd1,
    ST_EXEC   = 3'd2,
    ST_WAIT   = 3'd3,
    ST_WSTEP  = 3'd4,
    ST_LFETCH = 3'd5
  } ctl_state_t;

  // next timer value within a frame of 'ticks' cycles
  function automatic int unsigned tick_next(input int unsigned t, input int unsigned ticks);
    return (t + 1 >= ticks) ? 0 : t + 1;
  endfunction

  // frame number advance modulo 2**bits
  function automatic int unsigned frame_next(input int unsigned fn, input int unsigned bits);
    return (fn + 1) % (32'd1 << bits);
  endfunction

endpackage

// File: rtl/frame_clock.sv
module frame_clock #(
  parameter int unsigned TICKS_PER_FRAME = 48000,
  parameter int unsigned FRAME_BITS      = 10,
  parameter int unsigned TW              = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  count_en,
  input  logic                  tmr_clr,
  input  logic                  fnum_wr,
  input  logic [FRAME_BITS-1:0] fnum_wdata,
  output logic [TW-1:0]         timer,
  output logic [FRAME_BITS-1:0] frame_num,
  output logic                  sof
);
  localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_FRAME - 1);

  assign sof = count_en && (timer == LAST_TICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      timer     <= '0;
      frame_num <= '0;
    end else begin
      if (tmr_clr)
        timer <= '0;
      else if (count_en)
        timer <= TW'(sched_pkg::tick_next(32'(timer), TICKS_PER_FRAME));
      if (sof)
        frame_num <= FRAME_BITS'(sched_pkg::frame_next(32'(frame_num), FRAME_BITS));
      else if (fnum_wr && !count_en)
        frame_num <= fnum_wdata;
    end
  end

  // R2
  sof_adv_chk: assert property (@(posedge clk) disable iff (rst)
    sof |=> frame_num == FRAME_BITS'($past(frame_num) + 1'b1));

endmodule

// File: rtl/runctl_fsm.sv
module runctl_fsm (
  input  logic clk,
  input  logic rst,
  input  logic cmd_wr,
  input  logic cmd_run,
  input  logic cmd_dbg,
  input  logic desc_valid,
  input  logic desc_active,
  input  logic desc_last,
  input  logic exec_done,
  input  logic sof,
  output logic fetch_en,
  output logic run_bit,
  output logic dbg_bit,
  output logic halted,
  output logic count_en,
  output logic tmr_clr
);
  import sched_pkg::*;

  ctl_state_t state, state_nx;
  logic fetch_take, act_take, hw_clr, run_nx, dbg_nx;

  assign fetch_en   = (state == ST_RUN) || (state == ST_LFETCH);
  assign fetch_take = fetch_en && desc_valid;
  assign act_take   = (state == ST_RUN) && fetch_take && desc_active;
  assign hw_clr     = act_take && dbg_bit;
  assign run_nx     = (cmd_wr ? cmd_run : run_bit) && !hw_clr;
  assign dbg_nx     = cmd_wr ? cmd_dbg : dbg_bit;
  assign halted     = (state == ST_HALT);
  assign count_en   = !halted;
  assign tmr_clr    = (state != ST_HALT) && (state_nx == ST_HALT) && !dbg_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_HALT:   if (cmd_wr && cmd_run) state_nx = ST_RUN;
      ST_RUN:    if (act_take) state_nx = ST_EXEC;
                 else if (!run_nx) state_nx = ST_HALT;
      ST_EXEC:   if (exec_done) begin
                   if (!run_nx) state_nx = (dbg_nx && desc_last) ? ST_WSTEP : ST_HALT;
                   else         state_nx = desc_last ? ST_WAIT : ST_RUN;
                 end
      ST_WAIT:   if (sof) state_nx = run_nx ? ST_RUN : ST_HALT;
                 else if (!run_nx) state_nx = ST_HALT;
      ST_WSTEP:  if (sof) state_nx = ST_LFETCH;
      ST_LFETCH: if (fetch_take) state_nx = ST_HALT;
      default:   state_nx = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HALT;
      run_bit <= 1'b0;
      dbg_bit <= 1'b0;
    end else begin
      state   <= state_nx;
      run_bit <= run_nx;
      dbg_bit <= dbg_nx;
    end
  end

  // R8
  step_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (act_take && dbg_bit) |=> !run_bit && !fetch_en);

  // R5
  no_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && !exec_done) |=> (state == ST_EXEC));

  // R11
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (act_take && dbg_bit && cmd_wr && cmd_run) |=> !run_bit);

  // R9
  skip_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RUN) && fetch_take && !desc_active && !cmd_wr) |=> fetch_en && run_bit);

endmodule

// File: rtl/sched_runctl.sv
module sched_runctl #(
  parameter int unsigned TICKS_PER_FRAME = 48000,
  parameter int unsigned FRAME_BITS      = 10,
  localparam int unsigned TW = (TICKS_PER_FRAME > 1) ? $clog2(TICKS_PER_FRAME) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_wr,
  input  logic                  cmd_run,
  input  logic                  cmd_dbg,
  input  logic                  fnum_wr,
  input  logic [FRAME_BITS-1:0] fnum_wdata,
  input  logic                  desc_valid,
  input  logic                  desc_active,
  input  logic                  desc_last,
  input  logic                  exec_done,
  output logic                  fetch_en,
  output logic                  run_bit,
  output logic                  dbg_bit,
  output logic                  halted,
  output logic                  sof,
  output logic [TW-1:0]         frame_timer,
  output logic [FRAME_BITS-1:0] frame_num
);
  logic count_en, tmr_clr;

  runctl_fsm u_fsm (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_run(cmd_run), .cmd_dbg(cmd_dbg),
    .desc_valid(desc_valid), .desc_active(desc_active), .desc_last(desc_last),
    .exec_done(exec_done), .sof(sof), .fetch_en(fetch_en), .run_bit(run_bit),
    .dbg_bit(dbg_bit), .halted(halted), .count_en(count_en), .tmr_clr(tmr_clr)
  );

  frame_clock #(
    .TICKS_PER_FRAME(TICKS_PER_FRAME), .FRAME_BITS(FRAME_BITS), .TW(TW)
  ) u_clk (
    .clk(clk), .rst(rst), .count_en(count_en), .tmr_clr(tmr_clr),
    .fnum_wr(fnum_wr), .fnum_wdata(fnum_wdata),
    .timer(frame_timer), .frame_num(frame_num), .sof(sof)
  );

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && $past(halted)) |-> $stable(frame_timer) && $stable(frame_num) || $past(fnum_wr));

  // R6
  frnum_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && !sof) |=> frame_num == $past(frame_num));

  // R3
  halt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && cmd_wr && cmd_run) |=> !halted && run_bit && fetch_en);

  // R4
  stop_reset_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(halted) && !dbg_bit) |-> frame_timer == '0);

endmodule

// File: tb/sim_sched_runctl.sv
module sim_sched_runctl;
  localparam int TICKS = 8;
  localparam int FB    = 10;
  localparam int TWB   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 0, cmd_run = 0, cmd_dbg = 0, fnum_wr = 0;
  logic [FB-1:0] fnum_wdata = '0;
  logic desc_valid = 0, desc_active = 0, desc_last = 0, exec_done = 0;
  logic fetch_en, run_bit, dbg_bit, halted, sof;
  logic [TWB-1:0] frame_timer;
  logic [FB-1:0] frame_num;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sched_runctl #(.TICKS_PER_FRAME(TICKS), .FRAME_BITS(FB)) u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_run(cmd_run), .cmd_dbg(cmd_dbg),
    .fnum_wr(fnum_wr), .fnum_wdata(fnum_wdata), .desc_valid(desc_valid),
    .desc_active(desc_active), .desc_last(desc_last), .exec_done(exec_done),
    .fetch_en(fetch_en), .run_bit(run_bit), .dbg_bit(dbg_bit), .halted(halted),
    .sof(sof), .frame_timer(frame_timer), .frame_num(frame_num)
  );

  // {sample index, timer, sof, frame number} after the run write
  typedef struct packed { logic [7:0] idx; logic [7:0] tmr; logic sf; logic [9:0] fn; } vec_t;
  localparam vec_t VECS [10] = '{
    '{8'd0,  8'd0, 1'b0, 10'd1022}, '{8'd3,  8'd3, 1'b0, 10'd1022},
    '{8'd7,  8'd7, 1'b1, 10'd1022}, '{8'd8,  8'd0, 1'b0, 10'd1023},
    '{8'd12, 8'd4, 1'b0, 10'd1023}, '{8'd15, 8'd7, 1'b1, 10'd1023},
    '{8'd16, 8'd0, 1'b0, 10'd0},    '{8'd17, 8'd1, 1'b0, 10'd0},
    '{8'd23, 8'd7, 1'b1, 10'd0},    '{8'd24, 8'd0, 1'b0, 10'd1}
  };

  task automatic step();
    @(posedge clk); #1;
    cmd_wr = 0; fnum_wr = 0; desc_valid = 0; desc_active = 0; desc_last = 0; exec_done = 0;
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cmd(input logic r, input logic d);
    cmd_wr = 1; cmd_run = r; cmd_dbg = d;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cur;
    #1;
    step(); step(); step();
    rst = 0;
    // R1 reset state
    chk("R1 halted", halted, 1); chk("R1 run", run_bit, 0); chk("R1 dbg", dbg_bit, 0);
    chk("R1 fetch", fetch_en, 0); chk("R1 sof", sof, 0);
    chk("R1 timer", frame_timer, 0); chk("R1 fnum", frame_num, 0);

    // R6 accepted while halted
    fnum_wr = 1; fnum_wdata = 10'd1022; step();
    chk("R6 load halted", frame_num, 1022);
    // R3 start
    cmd(1, 0); step();
    chk("R3 halted", halted, 0); chk("R3 fetch", fetch_en, 1);

    // R2 table walk
    cur = 0;
    foreach (VECS[i]) begin
      while (cur < int'(VECS[i].idx)) begin step(); cur++; end
      chk("R2 timer", frame_timer, int'(VECS[i].tmr));
      chk("R2 sof", sof, int'(VECS[i].sf));
      chk("R2 fnum", frame_num, int'(VECS[i].fn));
    end

    // R6 ignored while running (timer 0 -> 1, no sof)
    fnum_wr = 1; fnum_wdata = 10'd500; step();
    chk("R6 ignored", frame_num, 1);

    // R4 normal stop
    cmd(0, 0); step();
    chk("R4 halted", halted, 1); chk("R4 timer", frame_timer, 0); chk("R4 fnum", frame_num, 1);
    fnum_wr = 1; fnum_wdata = 10'd5; step();
    cmd(1, 0); step();
    chk("R4 restart timer", frame_timer, 0); chk("R4 restart fnum", frame_num, 5);
    step();
    chk("R4 count", frame_timer, 1);

    // R5 finish descriptor in progress
    desc_valid = 1; desc_active = 1; step();
    chk("R5 fetch off in exec", fetch_en, 0);
    cmd(0, 0); step();
    chk("R5 run cleared", run_bit, 0); chk("R5 not halted", halted, 0);
    step(); step();
    chk("R5 still busy", halted, 0); chk("R5 fetch low", fetch_en, 0);
    exec_done = 1; step();
    chk("R5 halted after done", halted, 1); chk("R4 timer cleared", frame_timer, 0);

    // debug single step
    cmd(0, 1); step();
    cmd(1, 1); step();
    chk("R8 running", run_bit, 1);
    step(); step();
    desc_valid = 1; desc_active = 0; step();
    chk("R9 run kept", run_bit, 1); chk("R9 fetch kept", fetch_en, 1); chk("R9 not halted", halted, 0);
    desc_valid = 1; desc_active = 1; step();
    chk("R8 hw clear", run_bit, 0); chk("R8 fetch off", fetch_en, 0); chk("R8 not halted", halted, 0);
    chk("R8 timer", frame_timer, 4);
    exec_done = 1; step();
    chk("R8 halted", halted, 1); chk("R7 timer at stop", frame_timer, 5);
    step(); step(); step();
    chk("R7 frozen timer", frame_timer, 5); chk("R7 frozen fnum", frame_num, 5);
    cmd(1, 1); step();
    chk("R7 resume timer", frame_timer, 5);
    step();
    chk("R7 resume count", frame_timer, 6);

    // R11 collision: active fetch and run=1 write together
    desc_valid = 1; desc_active = 1; cmd(1, 1); step();
    chk("R11 hw clear wins", run_bit, 0); chk("R11 fetch off", fetch_en, 0);
    chk("R2 sof at last tick", sof, 1);
    // R10 last-in-frame step, done coincides with sof
    exec_done = 1; desc_last = 1; step();
    chk("R10 not halted", halted, 0); chk("R10 fetch low", fetch_en, 0);
    chk("R10 fnum", frame_num, 6); chk("R10 timer", frame_timer, 0);
    for (int k = 0; k < 7; k++) step();
    chk("R10 still waiting", fetch_en, 0); chk("R10 wait halted", halted, 0);
    step();
    chk("R10 fetch after sof", fetch_en, 1); chk("R10 fnum new", frame_num, 7);
    desc_valid = 1; desc_active = 0; step();
    chk("R10 halted on fetch", halted, 1); chk("R10 fetch dropped", fetch_en, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule